// File: doc/BRIEF.md
# Hot-Plug Command Engine

This block takes 16-bit commands from a register write port and carries them out for a group of hot-plug slots. Each command word names a target slot, counted from 1, in its upper byte and an operation code in its lower byte. The operation can change one slot's state and its two indicators, set the secondary bus speed/mode, or put every slot into power-only or enabled state at once.

Once a command is accepted the block shows busy for a fixed, parameterised number of cycles. That count stands in for the analog power sequencing, which is not modelled here. When the count runs out the block applies the change, drops busy, and pulses a one-cycle completion strobe. A command that is malformed, unsupported at the configured interface level, or blocked by an open retention latch produces an error code and changes nothing. The error code stays readable until the next command is accepted.

Top module: `hp_cmd_engine`

## Requirements
- R1: The command word has the target slot number (1-based) in bits 15:8 and the operation code in bits 7:0. The status port has busy in bit 0 and the error code in bits 3:1. Error values are 1 for a blocking latch, 2 for an invalid command and 4 for an invalid speed/mode.
- R2: A write accepted at a clock edge sets busy from the next cycle. Busy stays high for exactly EXEC_CYCLES cycles. The edge that clears busy also raises `cmd_done` for one cycle and updates the slot and mode outputs.
- R3: Codes 0x00 to 0x3F are slot operations. Code bits 1:0 set the slot state (1 power-only, 2 enabled, 3 disabled). Bits 3:2 set the power indicator and bits 5:4 set the attention indicator (1 on, 2 blink, 3 off). A zero sub-field leaves that item unchanged.
- R4: A slot operation whose state field is 1 or 2 on a slot with `latch_open` high reports error 1 and changes nothing. A disable is still allowed with the latch open.
- R5: Codes 0x40 to 0x44 set the bus mode to 0 to 4. Codes 0x45 to 0x47 report error 4 and change nothing.
- R6: Code 0x48 sets every slot to power-only and code 0x49 enables every slot. Indicators are left alone. If any latch is open the command reports error 1 and changes nothing.
- R7: At interface level 2, codes 0x50 to 0x5D set the bus mode to 0 to 13. At level 1 these codes report error 4. Codes 0x5E and 0x5F report error 4 at either level. At level 1 the bus mode never exceeds 4.
- R8: A slot operation with slot number 0 or greater than NUM_SLOTS reports error 2, and so do codes 0x4A to 0x4F and 0x60 to 0xFF. None of these changes anything.
- R9: A write presented while busy is high is ignored. It changes neither the busy length, nor the error, nor the result.
- R10: After reset every slot is disabled (3) with both indicators off (3). The bus mode is 0, busy and the error code are 0, and `cmd_done` is low.
- R11: The error code keeps its value from acceptance until the next accepted command, including the idle cycles after completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_word | input | 16 | Slot number [15:8], operation code [7:0] |
| latch_open | input | NUM_SLOTS | Retention latch open, one bit per slot |
| status | output | 4 | Busy [0], error code [3:1] |
| cmd_done | output | 1 | One-cycle completion pulse |
| slot_state | output | 2*NUM_SLOTS | Per-slot state, slot i at [2i+1:2i] |
| pwr_ind | output | 2*NUM_SLOTS | Per-slot power indicator |
| attn_ind | output | 2*NUM_SLOTS | Per-slot attention indicator |
| bus_mode | output | 4 | Current bus speed/mode code |

## Verification
The bench makes a new command write fall in a busy window that is already running. A second write is driven for one cycle in the middle of the window. The bench then judges that busy still ends on the original count and that the error and outputs reflect only the first command. It also makes a latch check coincide with a code that the latch does not block (disable with the latch open), and all-slot commands with a single open latch. Each outcome is compared with a bench model that computes the error and the resulting state from the requirements.

// File: rtl/hpc_pkg.sv
package hpc_pkg;

    localparam logic [2:0] ERR_NONE = 3'd0;
    localparam logic [2:0] ERR_SW   = 3'd1;
    localparam logic [2:0] ERR_CMD  = 3'd2;
    localparam logic [2:0] ERR_MODE = 3'd4;

    typedef enum logic [1:0] {
        ACT_NONE = 2'd0,
        ACT_SLOT = 2'd1,
        ACT_ALL  = 2'd2,
        ACT_MODE = 2'd3
    } act_e;

    typedef struct packed {
        act_e       act;
        logic [2:0] err;
        logic [7:0] slot_idx;
        logic [1:0] st;
        logic [1:0] pi;
        logic [1:0] ai;
        logic [3:0] mode;
    } cmd_dec_t;

    typedef struct packed {
        logic [1:0] st;
        logic [1:0] pi;
        logic [1:0] ai;
    } slot_t;

endpackage

// File: rtl/hp_cmd_decode.sv
module hp_cmd_decode
    import hpc_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int LEVEL     = 2
) (
    input  logic [15:0]          cmd_word,
    input  logic [NUM_SLOTS-1:0] latch_open,
    output cmd_dec_t             dec
);

    logic [7:0] code;
    logic [7:0] sl;
    logic       lat;

    always_comb begin
        code = cmd_word[7:0];
        sl   = cmd_word[15:8];
        lat  = 1'b0;
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (sl == 8'(i + 1)) lat = latch_open[i];
        end

        dec          = '0;
        dec.act      = ACT_NONE;
        dec.err      = ERR_NONE;
        dec.slot_idx = sl - 8'd1;
        dec.st       = code[1:0];
        dec.pi       = code[3:2];
        dec.ai       = code[5:4];
        dec.mode     = code[3:0];

        if (code <= 8'h3F) begin
            if (sl == 8'd0 || sl > 8'(NUM_SLOTS))
                dec.err = ERR_CMD;
            else if ((code[1:0] == 2'd1 || code[1:0] == 2'd2) && lat)
                dec.err = ERR_SW;
            else
                dec.act = ACT_SLOT;
        end else if (code <= 8'h44) begin
            dec.act = ACT_MODE;
        end else if (code <= 8'h47) begin
            dec.err = ERR_MODE;
        end else if (code <= 8'h49) begin
            dec.st = (code == 8'h48) ? 2'd1 : 2'd2;
            if (|latch_open) dec.err = ERR_SW;
            else             dec.act = ACT_ALL;
        end else if (code <= 8'h4F) begin
            dec.err = ERR_CMD;
        end else if (code <= 8'h5D) begin
            if (LEVEL >= 2) dec.act = ACT_MODE;
            else            dec.err = ERR_MODE;
        end else if (code <= 8'h5F) begin
            dec.err = ERR_MODE;
        end else begin
            dec.err = ERR_CMD;
        end
    end

endmodule

// File: rtl/hp_slot_bank.sv
module hp_slot_bank
    import hpc_pkg::*;
#(
    parameter int NUM_SLOTS = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   apply,
    input  cmd_dec_t               cmd,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic [2*NUM_SLOTS-1:0] pwr_ind,
    output logic [2*NUM_SLOTS-1:0] attn_ind
);

    localparam slot_t SLOT_RST = '{st: 2'd3, pi: 2'd3, ai: 2'd3};

    slot_t slot_d [NUM_SLOTS];
    slot_t slot_q [NUM_SLOTS];

    always_comb begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            slot_d[i] = slot_q[i];
            if (apply && cmd.act == ACT_SLOT && cmd.slot_idx == 8'(i)) begin
                if (cmd.st != 2'd0) slot_d[i].st = cmd.st;
                if (cmd.pi != 2'd0) slot_d[i].pi = cmd.pi;
                if (cmd.ai != 2'd0) slot_d[i].ai = cmd.ai;
            end else if (apply && cmd.act == ACT_ALL) begin
                slot_d[i].st = cmd.st;
            end
        end
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_SLOTS; i++) begin
            if (!rst_n) slot_q[i] <= SLOT_RST;
            else        slot_q[i] <= slot_d[i];
        end
    end

    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
        assign slot_state[2*g+1:2*g] = slot_q[g].st;
        assign pwr_ind[2*g+1:2*g]    = slot_q[g].pi;
        assign attn_ind[2*g+1:2*g]   = slot_q[g].ai;

        // R3: no slot ever holds the zero (no-change) encoding
        a_r3_state_legal: assert property (@(posedge clk) disable iff (!rst_n)
            slot_q[g].st != 2'd0 && slot_q[g].pi != 2'd0 && slot_q[g].ai != 2'd0);
        // R9: slots only move on a completion event from the control path
        a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
            !apply |=> $stable(slot_q[g]));
    end

endmodule

// File: rtl/hp_cmd_engine.sv
module hp_cmd_engine
    import hpc_pkg::*;
#(
    parameter int NUM_SLOTS   = 4,
    parameter int LEVEL       = 2,
    parameter int EXEC_CYCLES = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   cmd_wr,
    input  logic [15:0]            cmd_word,
    input  logic [NUM_SLOTS-1:0]   latch_open,
    output logic [3:0]             status,
    output logic                   cmd_done,
    output logic [2*NUM_SLOTS-1:0] slot_state,
    output logic [2*NUM_SLOTS-1:0] pwr_ind,
    output logic [2*NUM_SLOTS-1:0] attn_ind,
    output logic [3:0]             bus_mode
);

    localparam int CNT_W = $clog2(EXEC_CYCLES + 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [2:0]       err;
        cmd_dec_t         cmd;
        logic [3:0]       mode;
    } ctl_t;

    ctl_t     ctl_d, ctl_q;
    cmd_dec_t dec;
    logic     finish;

    hp_cmd_decode #(.NUM_SLOTS(NUM_SLOTS), .LEVEL(LEVEL)) u_decode (
        .cmd_word   (cmd_word),
        .latch_open (latch_open),
        .dec        (dec)
    );

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        finish     = ctl_q.busy && ctl_q.cnt == '0;
        if (ctl_q.busy) begin
            if (finish) begin
                ctl_d.busy = 1'b0;
                ctl_d.done = 1'b1;
                if (ctl_q.cmd.act == ACT_MODE) ctl_d.mode = ctl_q.cmd.mode;
            end else begin
                ctl_d.cnt = ctl_q.cnt - 1'b1;
            end
        end else if (cmd_wr) begin
            ctl_d.busy = 1'b1;
            ctl_d.cnt  = CNT_W'(EXEC_CYCLES - 1);
            ctl_d.err  = dec.err;
            ctl_d.cmd  = dec;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    hp_slot_bank #(.NUM_SLOTS(NUM_SLOTS)) u_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .apply      (finish),
        .cmd        (ctl_q.cmd),
        .slot_state (slot_state),
        .pwr_ind    (pwr_ind),
        .attn_ind   (attn_ind)
    );

    assign status   = {ctl_q.err, ctl_q.busy};
    assign cmd_done = ctl_q.done;
    assign bus_mode = ctl_q.mode;

    a_r2_busy_rises: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && !status[0] |=> status[0]);
    a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |=> !cmd_done);
    a_r2_done_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done |-> !status[0] && $past(status[0]));
    a_r11_err_hold: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] |=> $stable(status[3:1]));
    a_r9_busy_kept: assert property (@(posedge clk) disable iff (!rst_n)
        status[0] && cmd_wr && ctl_q.cnt != '0 |=> status[0]);
    a_r8_err_no_mode_change: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_done && status[3:1] != 3'd0 |-> $stable(bus_mode));
    a_r7_level1_mode: assert property (@(posedge clk) disable iff (!rst_n)
        LEVEL == 1 |-> bus_mode <= 4'd4);

endmodule

// File: tb/test_hp_cmd_engine.sv
`timescale 1ns/1ps
module test_hp_cmd_engine;

    localparam int N = 4;
    localparam int E = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_wr = 1'b0;
    logic [15:0]    cmd_word = '0;
    logic [N-1:0]   latch_open = '0;
    logic [3:0]     status, status1;
    logic           cmd_done, cmd_done1;
    logic [2*N-1:0] slot_state, pwr_ind, attn_ind;
    logic [2*N-1:0] st1, pi1, ai1;
    logic [3:0]     bus_mode, bus_mode1;

    int checks = 0;
    int failures = 0;
    int m_st [N];
    int m_pi [N];
    int m_ai [N];
    int m_mode2 = 0;
    int m_mode1 = 0;

    always #5 clk = ~clk;

    hp_cmd_engine #(.NUM_SLOTS(N), .LEVEL(2), .EXEC_CYCLES(E)) i_hp_cmd_engine (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .latch_open(latch_open), .status(status), .cmd_done(cmd_done),
        .slot_state(slot_state), .pwr_ind(pwr_ind), .attn_ind(attn_ind),
        .bus_mode(bus_mode));

    hp_cmd_engine #(.NUM_SLOTS(N), .LEVEL(1), .EXEC_CYCLES(E)) i_hp_cmd_engine_l1 (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
        .latch_open(latch_open), .status(status1), .cmd_done(cmd_done1),
        .slot_state(st1), .pwr_ind(pi1), .attn_ind(ai1),
        .bus_mode(bus_mode1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_err(input logic [15:0] w, input int lvl,
                                   input logic [N-1:0] lat);
        int c = w[7:0];
        int s = w[15:8];
        if (c <= 'h3F) begin
            if (s == 0 || s > N) return 2;
            if ((c % 4 == 1 || c % 4 == 2) && lat[s-1]) return 1;
            return 0;
        end
        if (c <= 'h44) return 0;
        if (c <= 'h47) return 4;
        if (c <= 'h49) return (lat != 0) ? 1 : 0;
        if (c <= 'h4F) return 2;
        if (c <= 'h5D) return (lvl == 2) ? 0 : 4;
        if (c <= 'h5F) return 4;
        return 2;
    endfunction

    function automatic int fld(input logic [2*N-1:0] v, input int i);
        return int'(v[2*i +: 2]);
    endfunction

    task automatic check_slots(input string req);
        for (int i = 0; i < N; i++) begin
            chk(req, fld(slot_state, i), m_st[i]);
            chk(req, fld(pwr_ind, i), m_pi[i]);
            chk(req, fld(attn_ind, i), m_ai[i]);
        end
    endtask

    task automatic issue(input logic [15:0] w, input logic [N-1:0] lat,
                         input bit inject, input string req);
        int e2, e1, c, s;
        bit busy_ok;
        e2 = exp_err(w, 2, lat);
        e1 = exp_err(w, 1, lat);
        c  = w[7:0];
        s  = w[15:8];
        @(negedge clk);
        latch_open = lat;
        cmd_word = w;
        cmd_wr = 1'b1;
        @(negedge clk);
        cmd_wr = 1'b0;
        latch_open = '0;
        busy_ok = (status[0] == 1'b1) && (status1[0] == 1'b1);
        for (int k = 1; k < E; k++) begin
            if (inject && k == 1) begin
                cmd_word = 16'h0149;
                cmd_wr = 1'b1;
            end
            @(negedge clk);
            cmd_wr = 1'b0;
            if (status[0] != 1'b1 || cmd_done) busy_ok = 0;
        end
        chk({req, " R2 busy window"}, busy_ok, 1);
        @(negedge clk);
        // model update for the level-2 instance
        if (e2 == 0) begin
            if (c <= 'h3F) begin
                if (c % 4 != 0)        m_st[s-1] = c % 4;
                if ((c / 4) % 4 != 0)  m_pi[s-1] = (c / 4) % 4;
                if ((c / 16) % 4 != 0) m_ai[s-1] = (c / 16) % 4;
            end else if (c <= 'h44) m_mode2 = c - 'h40;
            else if (c == 'h48) for (int i = 0; i < N; i++) m_st[i] = 1;
            else if (c == 'h49) for (int i = 0; i < N; i++) m_st[i] = 2;
            else m_mode2 = c - 'h50;
        end
        if (e1 == 0 && c >= 'h40 && c <= 'h44) m_mode1 = c - 'h40;
        chk({req, " R2 done pulse"}, {status[0], cmd_done}, 1);
        chk({req, " R1 error code"}, status[3:1], e2);
        chk({req, " R7 level1 error"}, status1[3:1], e1);
        chk({req, " R5 bus mode"}, bus_mode, m_mode2);
        chk({req, " R7 level1 mode"}, bus_mode1, m_mode1);
        check_slots({req, " R3 slots"});
        @(negedge clk);
        chk({req, " R11 error held"}, {cmd_done, status}, {1'b0, 3'(e2), 1'b0});
    endtask

    initial begin
        #(200000 * 10);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < N; i++) begin
            m_st[i] = 3; m_pi[i] = 3; m_ai[i] = 3;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk("R10 status", status, 0);
        chk("R10 done", cmd_done, 0);
        chk("R10 mode", bus_mode, 0);
        check_slots("R10 slots");

        issue(16'h013A, '0, 0, "R3 enable slot1 blink off");
        issue(16'h0200, '0, 0, "R3 zero fields no change");
        issue(16'h0414, '0, 0, "R3 slot4 pwr on attn on");
        issue(16'h0001, '0, 0, "R8 slot zero");
        issue(16'h0501, '0, 0, "R8 slot above count");
        issue(16'h0301, 4'b0100, 0, "R4 power-only latch open");
        issue(16'h0302, 4'b0100, 0, "R4 enable latch open");
        issue(16'h0303, 4'b0100, 0, "R4 disable latch open allowed");
        issue(16'h0144, '0, 0, "R5 mode A 133");
        issue(16'h0145, '0, 0, "R5 reserved mode A");
        issue(16'h0148, 4'b1000, 0, "R6 power-only all latch open");
        issue(16'h0148, '0, 0, "R6 power-only all");
        issue(16'h0149, '0, 0, "R6 enable all");
        issue(16'h015D, '0, 0, "R7 mode B top");
        issue(16'h015E, '0, 0, "R7 reserved mode B");
        issue(16'h014A, '0, 0, "R8 reserved 4A");
        issue(16'h0160, '0, 0, "R8 reserved 60");
        issue(16'h01C3, '0, 0, "R8 vendor range");
        issue(16'h0233, '0, 1, "R9 write during busy");
        issue(16'h0140, '0, 1, "R9 mode write during busy");

        for (int n = 0; n < 150; n++) begin
            logic [15:0] w;
            logic [N-1:0] lat;
            int cat = $urandom % 8;
            w[15:8] = 8'($urandom % (N + 2));
            case (cat)
                0, 1, 2: w[7:0] = 8'($urandom % 64);
                3:       w[7:0] = 8'('h40 + $urandom % 8);
                4:       w[7:0] = 8'('h48 + $urandom % 8);
                5:       w[7:0] = 8'('h50 + $urandom % 16);
                default: w[7:0] = 8'($urandom % 256);
            endcase
            lat = ($urandom % 4 == 0) ? N'($urandom) : '0;
            issue(w, lat, ($urandom % 5) == 0, "R3 random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule